// File: doc/BRIEF.md
# PCIe MSI Receiver and Vector Interrupt Controller

This block sits behind the inbound side of a PCIe root port and watches memory writes that the link layers have already decoded. A write counts as a message-signalled interrupt when the block is enabled, the write address equals a programmed target address, and the low data half matches a programmed pattern wherever a programmed mask has ones. The data bits under the mask's low zero bits select a vector. That vector's bit is then set in a status register.

Software programs the target address, the pattern and the mask through a small indexed register interface. It services interrupts by reading status and clearing bits with write-one-to-clear. Per-vector mask bits gate a single level interrupt output. A build parameter picks one of two vector layouts. The wide layout has 32 vectors at status bits 0..31. The legacy layout has 8 vectors at status bits 24..31.

Top module: `msi_irq_ctrl`

## Requirements
- R1: On the first clock edge with `rst_n` low, the block resets. Status is all zero, every mask bit inside the vector window is 1, the enable bit is 0, and `irq_o` is 0.
- R2: A write with `in_valid` high sets one status bit at the next edge when all of these hold. Bit 0 of the address-low register (index 0) is 1. `in_addr` equals {address-high register (index 1), address-low bits 31:2, 2'b00}. `in_data[31:16]` is zero. `(in_data[15:0] & M) == (V & M)`, where the data register (index 2) holds M in bits 31:16 and V in bits 15:0.
- R3: The vector number is `in_data[15:0] & ~M`. In the wide layout it sets status bit `vector`. In the legacy layout it sets status bit `24 + vector`. A vector of 32 or more (wide) or 8 or more (legacy) sets nothing.
- R4: A write that fails the address compare, the masked data compare or the zero-upper-half rule changes no status bit.
- R5: While the enable bit is 0, no inbound write changes status.
- R6: Writing index 4 sets status bits where the data has ones. Writing index 5 clears them. Status bits otherwise hold, and status (index 3) is read-only.
- R7: When an accepted message and a clear write of its own bit land in the same cycle, the bit ends up set.
- R8: Writing index 6 sets mask bits and writing index 7 clears them, both by writing ones. Index 8 reads the mask. `irq_o` is the OR of status AND NOT mask. Masked vectors still record status.
- R9: In the legacy layout, status and mask bits 0..23 always read 0. Set or mask writes to those bits have no effect.
- R10: Index 0 and index 2 read back all 32 written bits. Index 1 reads back its ADDR_W-32 bits, zero-extended.
- R11: Target addresses above 4 GB (up to 36 bits by default) are matched through the address-high register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inbound memory write strobe |
| in_addr | input | ADDR_W | Inbound write byte address |
| in_data | input | 32 | Inbound write data |
| reg_wen | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at `reg_idx` (combinational) |
| irq_o | output | 1 | Level interrupt: any unmasked status bit set |

## Verification
A wrong status bit reaches the ports within one clock edge. It shows at index 3 and in `irq_o` right after the edge that should have captured or cleared it. A corrupt mask shows as an `irq_o` level that disagrees with the status and mask read through indices 3 and 8. A mis-wired vector offset or a wrong compare sets a neighbouring bit, or sets nothing. Both outcomes are visible at the status read after a single accepted or rejected write. Running both layouts on identical stimulus exposes offset errors, because each layout expects a different bit.

// File: rtl/msi_pkg.sv
// Package: register indices and shared constants of the MSI receiver.
// Assumes a single 32-bit status word covering every vector layout.
package msi_pkg;

    localparam int STAT_W  = 32;
    localparam int DATA_W  = 32;
    localparam int IDX_W   = 4;

    typedef enum logic [IDX_W-1:0] {
        RG_ADDR_LO  = 4'd0,
        RG_ADDR_HI  = 4'd1,
        RG_DATA_CFG = 4'd2,
        RG_STATUS   = 4'd3,
        RG_SET      = 4'd4,
        RG_CLR      = 4'd5,
        RG_MASK_SET = 4'd6,
        RG_MASK_CLR = 4'd7,
        RG_MASK_VIEW= 4'd8
    } reg_sel_e;

    // Window of status bits used by a layout.
    function automatic logic [STAT_W-1:0] win_mask(input bit legacy);
        return legacy ? 32'hFF00_0000 : 32'hFFFF_FFFF;
    endfunction

endpackage

// File: rtl/msi_cfg_regs.sv
// Module: configuration registers (target address low/high, data pattern).
// Assumes writes are single-cycle strobes. Bit 0 of address-low is the enable.
module msi_cfg_regs
    import msi_pkg::*;
#(
    parameter int ADDR_W = 36,
    localparam int HI_W = ADDR_W - 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [31:0]       addr_lo_q,
    output logic [HI_W-1:0]   addr_hi_q,
    output logic [31:0]       data_cfg_q
);

    // Capture software writes to the three configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo_q  <= '0;
            addr_hi_q  <= '0;
            data_cfg_q <= '0;
        end else if (reg_wen) begin
            if (reg_idx == RG_ADDR_LO)  addr_lo_q  <= reg_wdata;
            if (reg_idx == RG_ADDR_HI)  addr_hi_q  <= reg_wdata[HI_W-1:0];
            if (reg_idx == RG_DATA_CFG) data_cfg_q <= reg_wdata;
        end
    end

endmodule

// File: rtl/msi_match.sv
// Module: decides whether an inbound write is a message and which vector it hits.
// Produces a one-hot (or zero) status-bit vector in the same cycle.
// Assumes the data config holds the mask in [31:16] and the pattern in [15:0].
module msi_match
    import msi_pkg::*;
#(
    parameter int ADDR_W = 36,
    parameter bit LEGACY = 1'b0,
    localparam int HI_W    = ADDR_W - 32,
    localparam int VEC_OFS = LEGACY ? 24 : 0,
    localparam int NVEC    = LEGACY ? 8 : 32
) (
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [31:0]       addr_lo,
    input  logic [HI_W-1:0]   addr_hi,
    input  logic [31:0]       data_cfg,
    output logic [STAT_W-1:0] hit_vec
);

    logic [ADDR_W-1:0] target;
    logic [15:0]       cmp_mask;
    logic [15:0]       vec_num;
    logic              addr_ok, data_ok, vec_ok;
    logic [4:0]        bit_pos;

    // Qualify the write and compute the status bit it targets.
    always_comb begin
        target   = {addr_hi, addr_lo[31:2], 2'b00};
        cmp_mask = data_cfg[31:16];
        addr_ok  = (in_addr == target);
        data_ok  = (in_data[31:16] == 16'h0) &&
                   ((in_data[15:0] & cmp_mask) == (data_cfg[15:0] & cmp_mask));
        vec_num  = in_data[15:0] & ~cmp_mask;
        vec_ok   = (vec_num < 16'(NVEC));
        bit_pos  = 5'(VEC_OFS) + vec_num[4:0];
        hit_vec  = '0;
        if (in_valid && addr_lo[0] && addr_ok && data_ok && vec_ok)
            hit_vec[bit_pos] = 1'b1;
    end

endmodule

// File: rtl/msi_vec_state.sv
// Module: per-vector status and mask flops plus the interrupt OR tree.
// Bits outside the layout window are tied to zero. A message beats a clear.
module msi_vec_state
    import msi_pkg::*;
#(
    parameter bit LEGACY = 1'b0,
    localparam logic [STAT_W-1:0] WIN = win_mask(LEGACY)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] hit_vec,
    input  logic [STAT_W-1:0] sw_set,
    input  logic [STAT_W-1:0] sw_clr,
    input  logic [STAT_W-1:0] msk_set,
    input  logic [STAT_W-1:0] msk_clr,
    output logic [STAT_W-1:0] stat_q,
    output logic [STAT_W-1:0] mask_q,
    output logic              irq_o
);

    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        if (WIN[b]) begin : g_live
            // Status bit: set by message or software, cleared by W1C.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stat_q[b] <= 1'b0;
                else
                    stat_q[b] <= hit_vec[b] | sw_set[b] | (stat_q[b] & ~sw_clr[b]);
            end
            // Mask bit: reset to masked, W1S / W1C from software.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mask_q[b] <= 1'b1;
                else
                    mask_q[b] <= (mask_q[b] | msk_set[b]) & ~msk_clr[b];
            end
        end else begin : g_dead
            assign stat_q[b] = 1'b0;
            assign mask_q[b] = 1'b0;
        end
    end

    // Level interrupt from any pending unmasked vector.
    assign irq_o = |(stat_q & ~mask_q);

endmodule

// File: rtl/msi_irq_ctrl.sv
// Module: top of the MSI receiver. Decodes register writes, builds the read
// mux and wires the config, match and vector-state blocks together.
// Assumes ADDR_W > 32 and one register access per cycle.
module msi_irq_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 36,
    parameter bit LEGACY = 1'b0,
    localparam int HI_W = ADDR_W - 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [31:0]       in_data,
    input  logic              reg_wen,
    input  logic [3:0]        reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_o
);

    logic [31:0]       addr_lo_q, data_cfg_q;
    logic [HI_W-1:0]   addr_hi_q;
    logic [STAT_W-1:0] hit_vec, stat_q, mask_q;
    logic [STAT_W-1:0] sw_set, sw_clr, msk_set, msk_clr;
    logic              en;

    assign en = addr_lo_q[0];

    msi_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .addr_lo_q(addr_lo_q), .addr_hi_q(addr_hi_q),
        .data_cfg_q(data_cfg_q)
    );

    msi_match #(.ADDR_W(ADDR_W), .LEGACY(LEGACY)) u_match (
        .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
        .addr_lo(addr_lo_q), .addr_hi(addr_hi_q), .data_cfg(data_cfg_q),
        .hit_vec(hit_vec)
    );

    // Turn a register write into per-bit set/clear strobes.
    always_comb begin
        sw_set  = (reg_wen && reg_idx == RG_SET)      ? reg_wdata : '0;
        sw_clr  = (reg_wen && reg_idx == RG_CLR)      ? reg_wdata : '0;
        msk_set = (reg_wen && reg_idx == RG_MASK_SET) ? reg_wdata : '0;
        msk_clr = (reg_wen && reg_idx == RG_MASK_CLR) ? reg_wdata : '0;
    end

    msi_vec_state #(.LEGACY(LEGACY)) u_state (
        .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .sw_set(sw_set),
        .sw_clr(sw_clr), .msk_set(msk_set), .msk_clr(msk_clr),
        .stat_q(stat_q), .mask_q(mask_q), .irq_o(irq_o)
    );

    // Read mux over the register indices; write-only indices read zero.
    always_comb begin
        case (reg_idx)
            RG_ADDR_LO:   reg_rdata = addr_lo_q;
            RG_ADDR_HI:   reg_rdata = 32'(addr_hi_q);
            RG_DATA_CFG:  reg_rdata = data_cfg_q;
            RG_STATUS:    reg_rdata = stat_q;
            RG_MASK_VIEW: reg_rdata = mask_q;
            default:      reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/msi_irq_ctrl_chk.sv
// Checker: temporal properties of the MSI receiver, bound to the top module.
module msi_irq_ctrl_chk
    import msi_pkg::*;
#(
    parameter bit LEGACY = 1'b0,
    localparam logic [STAT_W-1:0] WIN = win_mask(LEGACY)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              reg_wen,
    input logic [3:0]        reg_idx,
    input logic [31:0]       reg_wdata,
    input logic [STAT_W-1:0] stat,
    input logic [STAT_W-1:0] mask,
    input logic              en,
    input logic              irq_o
);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stat == '0 && mask == WIN && !en && !irq_o)); // R1

    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !reg_wen) |=> $stable(stat)); // R5

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_idx == RG_CLR && !in_valid) |=> ((stat & $past(reg_wdata)) == '0)); // R6

    AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wen) |=> ((stat & $past(stat)) == $past(stat))); // R6

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask & WIN) == WIN) |-> !irq_o); // R8

    AST_WINDOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ~WIN) == '0) && ((mask & ~WIN) == '0)); // R9

endmodule

bind msi_irq_ctrl msi_irq_ctrl_chk #(.LEGACY(LEGACY)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .reg_wen(reg_wen),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .stat(stat_q), .mask(mask_q),
    .en(en), .irq_o(irq_o)
);

// File: tb/msi_irq_ctrl_tb.sv
// Bench: drives the wide and legacy layouts with identical stimulus and
// compares each against independently computed expectations.
module msi_irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 36;

    typedef struct packed {
        logic [35:0] a;
        logic [31:0] d;
        logic [31:0] exp_w;
        logic [31:0] exp_l;
    } vec_t;

    // Table phase: target 0x0_FFFF_FFFC enabled, mask FFE0, pattern 6540.
    localparam vec_t TBL [8] = '{
        '{36'h0_FFFF_FFFC, 32'h0000_6540, 32'h0000_0001, 32'h0100_0000}, // R2 R3 vec0
        '{36'h0_FFFF_FFFC, 32'h0000_6545, 32'h0000_0020, 32'h2000_0000}, // R3 vec5
        '{36'h0_FFFF_FFFC, 32'h0000_655F, 32'h8000_0000, 32'h0000_0000}, // R3 vec31, beyond legacy
        '{36'h0_FFFF_FFFC, 32'h0000_6440, 32'h0000_0000, 32'h0000_0000}, // R4 pattern miss
        '{36'h0_FFFF_FFF8, 32'h0000_6540, 32'h0000_0000, 32'h0000_0000}, // R4 addr miss
        '{36'h1_FFFF_FFFC, 32'h0000_6540, 32'h0000_0000, 32'h0000_0000}, // R4 high addr miss
        '{36'h0_FFFF_FFFC, 32'h0000_6547, 32'h0000_0080, 32'h8000_0000}, // R3 vec7
        '{36'h0_FFFF_FFFC, 32'hABCD_6542, 32'h0000_0000, 32'h0000_0000}  // R4 upper half
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic reg_wen = 1'b0;
    logic [3:0] reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rdata_w, rdata_l;
    logic irq_w, irq_l;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_irq_ctrl #(.ADDR_W(ADDR_W), .LEGACY(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_data(in_data), .reg_wen(reg_wen), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_w), .irq_o(irq_w)
    );

    msi_irq_ctrl #(.ADDR_W(ADDR_W), .LEGACY(1'b1)) dut_leg_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_data(in_data), .reg_wen(reg_wen), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_l), .irq_o(irq_l)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] val);
        @(negedge clk);
        reg_wen = 1'b1; reg_idx = idx; reg_wdata = val;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic msi(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx);
        reg_idx = idx;
        #1;
    endtask

    task automatic both(input string tag, input logic [3:0] idx,
                        input logic [31:0] ew, input logic [31:0] el);
        rd(idx);
        chk({tag, " wide"}, rdata_w, ew);
        chk({tag, " legacy"}, rdata_l, el);
    endtask

    task automatic irqs(input string tag, input logic ew, input logic el);
        chk({tag, " irq wide"}, 32'(irq_w), 32'(ew));
        chk({tag, " irq legacy"}, 32'(irq_l), 32'(el));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        both("R1 status", 4'd3, 32'h0, 32'h0);
        both("R1 mask", 4'd8, 32'hFFFF_FFFF, 32'hFF00_0000);
        both("R1 addr_lo", 4'd0, 32'h0, 32'h0);
        irqs("R1", 1'b0, 1'b0);

        // R5 disabled: configured but enable bit clear
        wr(4'd1, 32'h0);
        wr(4'd2, 32'hFFE0_6540);
        wr(4'd0, 32'hFFFF_FFFC);
        msi(36'h0_FFFF_FFFC, 32'h6540);
        both("R5 disabled", 4'd3, 32'h0, 32'h0);

        // R8 masked vectors record status without interrupt
        wr(4'd0, 32'hFFFF_FFFD);
        msi(36'h0_FFFF_FFFC, 32'h6540);
        both("R8 masked status", 4'd3, 32'h1, 32'h0100_0000);
        irqs("R8 masked", 1'b0, 1'b0);
        wr(4'd7, 32'h0000_0001);
        irqs("R8 unmask bit0", 1'b1, 1'b0);
        wr(4'd7, 32'h0100_0000);
        irqs("R8 unmask bit24", 1'b1, 1'b1);
        both("R9 mask view", 4'd8, 32'hFEFF_FFFE, 32'hFE00_0000);
        wr(4'd6, 32'h0100_0001);
        irqs("R8 remask", 1'b0, 1'b0);

        // R10 readback
        both("R10 addr_lo", 4'd0, 32'hFFFF_FFFD, 32'hFFFF_FFFD);
        both("R10 data_cfg", 4'd2, 32'hFFE0_6540, 32'hFFE0_6540);

        // Table phase: all unmasked
        wr(4'd7, 32'hFFFF_FFFF);
        for (int i = 0; i < 8; i++) begin
            wr(4'd5, 32'hFFFF_FFFF);
            msi(TBL[i].a, TBL[i].d);
            both($sformatf("R2/R3/R4 entry %0d", i), 4'd3, TBL[i].exp_w, TBL[i].exp_l);
            irqs($sformatf("R8 entry %0d", i), TBL[i].exp_w != 0, TBL[i].exp_l != 0);
        end

        // R7 message beats a same-cycle clear
        wr(4'd5, 32'hFFFF_FFFF);
        msi(36'h0_FFFF_FFFC, 32'h6545);
        @(negedge clk);
        reg_wen = 1'b1; reg_idx = 4'd5; reg_wdata = 32'h2000_0020;
        in_valid = 1'b1; in_addr = 36'h0_FFFF_FFFC; in_data = 32'h6545;
        @(negedge clk);
        reg_wen = 1'b0; in_valid = 1'b0;
        both("R7 collide", 4'd3, 32'h20, 32'h2000_0000);
        wr(4'd5, 32'h2000_0020);
        both("R6 clear", 4'd3, 32'h0, 32'h0);

        // R6 / R9 software set, status read-only
        wr(4'd4, 32'h0000_0004);
        both("R9 set low", 4'd3, 32'h4, 32'h0);
        wr(4'd4, 32'h8000_0000);
        both("R6 set high", 4'd3, 32'h8000_0004, 32'h8000_0000);
        irqs("R6 set", 1'b1, 1'b1);
        wr(4'd3, 32'h0);
        both("R6 status ro", 4'd3, 32'h8000_0004, 32'h8000_0000);

        // R3 eight-vector mask
        wr(4'd2, 32'hFFF8_6540);
        wr(4'd5, 32'hFFFF_FFFF);
        msi(36'h0_FFFF_FFFC, 32'h6543);
        both("R3 8vec hit", 4'd3, 32'h8, 32'h0800_0000);
        wr(4'd5, 32'hFFFF_FFFF);
        msi(36'h0_FFFF_FFFC, 32'h6548);
        both("R4 8vec miss", 4'd3, 32'h0, 32'h0);

        // R11 target above 4 GB
        wr(4'd1, 32'h0000_000F);
        wr(4'd2, 32'hFFE0_6540);
        both("R10 addr_hi", 4'd1, 32'hF, 32'hF);
        msi(36'hF_FFFF_FFFC, 32'h6541);
        both("R11 high hit", 4'd3, 32'h2, 32'h0200_0000);
        wr(4'd5, 32'hFFFF_FFFF);
        msi(36'h0_FFFF_FFFC, 32'h6541);
        both("R11 low miss", 4'd3, 32'h0, 32'h0);

        // R5 disable again
        wr(4'd0, 32'hFFFF_FFFC);
        msi(36'hF_FFFF_FFFC, 32'h6541);
        both("R5 redisabled", 4'd3, 32'h0, 32'h0);
        irqs("R5", 1'b0, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule